// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Front End

This block is the transmit side of a small Ethernet MAC as seen from a host processor. Software fills one of two frame buffers through a 32-bit word bus, writes the frame length into that buffer's length word, and then writes the buffer's control word. The control write either sends the buffered bytes out of a byte-wide valid/ready stream, or copies the first six buffer bytes into the station address register. Preamble, FCS and line signalling belong to later stages.

One engine serves both buffers. When both are pending as the engine falls idle, buffer 0 goes first. While a buffer's operation runs, its start bit, and its program bit for a program operation, read back as 1. Both clear themselves when the operation ends. At that point a one-cycle interrupt pulse can be raised, gated per buffer and by one global enable.

Top module: `dual_buf_tx_mac`

## Requirements
- R1: After reset, `txValid`, `txLast` and `irqPulse` are 0, `stationAddr` equals the `STATION_RESET` parameter, and both control words read 0.
- R2: Byte addresses: buffer 0 data words start at 0x000 and buffer 1 data words start at 0x800. The length words are at 0x7F4 and 0xFF4 and keep only bits 10:0. The global enable is at 0x7F8 and keeps only bit 31. The control words are at 0x7FC and 0xFFC. The unused slot at 0xFF8 reads 0. Read data appears on `busRdData` one cycle after `busRdEn`.
- R3: A control write with bit 0 = 1 and bit 1 = 0 sends exactly the length word's number of bytes from that buffer, lowest address first. Within a data word, bits 31:24 go first. `txLast` is high on the final byte only.
- R4: While `txValid` is high and `txReady` is low, `txValid`, `txData` and `txLast` hold their values.
- R5: A control write with bits 1:0 = 11 sends no bytes. It loads `stationAddr[47:40]` from buffer byte 0 through `stationAddr[7:0]` from buffer byte 5.
- R6: While an operation runs, control bit 0 reads 1, and bit 1 reads 1 for a program operation. After completion both read 0. Bits 31:2 always read their last written value.
- R7: A control write to a busy buffer updates bits 31:2 only. Its bits 1:0 start no further operation.
- R8: On completion, `irqPulse` is high for exactly one cycle if that buffer's control bit 3 is 1 and global enable bit 31 is 1. Otherwise it stays low.
- R9: A send with length 0 completes with no bytes on the stream. It still clears bit 0 and follows R8.
- R10: A control write with bit 0 = 0 starts nothing, whatever its bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address; bits 1:0 ignored |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe for one cycle |
| busRdData | output | 32 | Read data, valid the cycle after `busRdEn` |
| txData | output | 8 | Transmit byte |
| txValid | output | 1 | Transmit byte valid |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Downstream accepts the byte |
| stationAddr | output | 48 | Station MAC address |
| irqPulse | output | 1 | One-cycle completion interrupt |

## Verification
Most internal faults here surface at the ports within a frame. A byte counter or lane select that is wrong reorders or truncates the byte stream, and `txLast` lands on the wrong byte. A busy flag that never clears leaves bit 0 stuck at 1 when software polls the control word, and no further frame is sent. A flag that clears early or is set twice gives a missing or repeated frame. A wrong interrupt gate shows as an extra or missing `irqPulse` in the cycle after the engine finishes. A pulse wider than one cycle shows at once.

// File: rtl/txfront_pkg.sv
package txfront_pkg;
  // Words per buffer window is 2**BUF_IDX_W (2 KiB window at 9).
  parameter int unsigned BUF_IDX_W = 9;

  typedef enum logic [2:0] {
    EngIdle,
    EngLoad,
    EngSend,
    EngMacHi,
    EngMacLo,
    EngDone
  } engState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic                 rdReq;
    logic                 rdBuf;
    logic [BUF_IDX_W-1:0] rdIdx;
    logic [1:0]           lane;
    logic                 macHi;
    logic                 macLo;
  } dpCmd_t;
endpackage

// File: rtl/tx_datapath.sv
module tx_datapath
  import txfront_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter logic [47:0] STATION_RESET = 48'h02_00_00_00_00_01,
  localparam int unsigned ADDR_W = BUF_IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic [31:0]       ctrlWord0,
  input  logic [31:0]       ctrlWord1,
  input  dpCmd_t            cmd,
  output logic [LEN_W-1:0]  len0,
  output logic [LEN_W-1:0]  len1,
  output logic              gieOn,
  output logic [7:0]        txData,
  output logic [47:0]       stationAddr
);
  localparam int unsigned WORDS   = 2 ** BUF_IDX_W;
  localparam int unsigned IDX_LEN = WORDS - 3;
  localparam int unsigned IDX_GIE = WORDS - 2;
  localparam int unsigned IDX_CTL = WORDS - 1;

  logic [31:0] mem [2*WORDS];
  logic [31:0] engQ;

  logic                 bufBit;
  logic [BUF_IDX_W-1:0] idx;
  logic                 isData, isLen, isGie, isCtl;

  assign bufBit = busAddr[ADDR_W-1];
  assign idx    = busAddr[ADDR_W-2:2];
  assign isData = (32'(idx) < IDX_LEN);
  assign isLen  = (32'(idx) == IDX_LEN);
  assign isGie  = (32'(idx) == IDX_GIE);
  assign isCtl  = (32'(idx) == IDX_CTL);

  // Frame storage, one write port for the bus.
  always_ff @(posedge clk) begin
    if (busWrEn && isData) mem[{bufBit, idx}] <= busWrData;
  end

  // Engine read port: holds its word until the next request.
  always_ff @(posedge clk) begin
    if (!rstN) engQ <= '0;
    else if (cmd.rdReq) engQ <= mem[{cmd.rdBuf, cmd.rdIdx}];
  end

  // Length and global enable.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      len0  <= '0;
      len1  <= '0;
      gieOn <= 1'b0;
    end else if (busWrEn) begin
      if (isLen && !bufBit) len0 <= busWrData[LEN_W-1:0];
      if (isLen && bufBit)  len1 <= busWrData[LEN_W-1:0];
      if (isGie && !bufBit) gieOn <= busWrData[31];
    end
  end

  // Bus read, one cycle latency.
  always_ff @(posedge clk) begin
    if (!rstN) busRdData <= '0;
    else if (busRdEn) begin
      if (isData)     busRdData <= mem[{bufBit, idx}];
      else if (isLen) busRdData <= 32'(bufBit ? len1 : len0);
      else if (isGie) busRdData <= bufBit ? 32'h0 : {gieOn, 31'h0};
      else            busRdData <= bufBit ? ctrlWord1 : ctrlWord0;
    end
  end

  // Station address capture, big-endian bytes.
  always_ff @(posedge clk) begin
    if (!rstN) stationAddr <= STATION_RESET;
    else begin
      if (cmd.macHi) stationAddr[47:16] <= engQ;
      if (cmd.macLo) stationAddr[15:0]  <= engQ[31:16];
    end
  end

  assign txData = engQ[31 - 8*cmd.lane -: 8];

  AST_MAC_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.macHi |=> cmd.macLo); // R5
  AST_LO_AFTER_HI: assert property (@(posedge clk) disable iff (!rstN)
    cmd.macLo |-> $past(cmd.macHi)); // R5
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
  import txfront_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  localparam int unsigned ADDR_W = BUF_IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic [LEN_W-1:0]  len0,
  input  logic [LEN_W-1:0]  len1,
  input  logic              gieOn,
  input  logic              txReady,
  output logic              txValid,
  output logic              txLast,
  output logic              irqPulse,
  output dpCmd_t            cmd,
  output logic [31:0]       ctrlWord0,
  output logic [31:0]       ctrlWord1
);
  localparam int unsigned IRQ_EN_POS = 1; // bit 3 of control within bits 31:2

  engState_t        state;
  logic             curBuf;
  logic [LEN_W-1:0] byteCnt;
  logic [29:0]      keepBits [2];
  logic [1:0]       busy;
  logic [1:0]       progOp;

  logic             ctlHit;
  logic             wrBuf;
  logic [LEN_W-1:0] curLen;
  logic             pickBuf;
  logic             isLastByte;

  assign wrBuf   = busAddr[ADDR_W-1];
  assign ctlHit  = busWrEn && (busAddr[ADDR_W-2:2] == '1);
  assign curLen  = curBuf ? len1 : len0;
  assign pickBuf = !busy[0];
  assign isLastByte = (byteCnt == curLen - LEN_W'(1));

  assign ctrlWord0 = {keepBits[0], busy[0] & progOp[0], busy[0]};
  assign ctrlWord1 = {keepBits[1], busy[1] & progOp[1], busy[1]};

  // Control words, busy flags and the engine sequence.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= EngIdle;
      curBuf   <= 1'b0;
      byteCnt  <= '0;
      busy     <= '0;
      progOp   <= '0;
      irqPulse <= 1'b0;
      for (int b = 0; b < 2; b++) keepBits[b] <= '0;
    end else begin
      irqPulse <= 1'b0;
      if (ctlHit) begin
        keepBits[wrBuf] <= busWrData[31:2];
        if (!busy[wrBuf] && busWrData[0]) begin
          busy[wrBuf]   <= 1'b1;
          progOp[wrBuf] <= busWrData[1];
        end
      end
      unique case (state)
        EngIdle: begin
          if (busy != 2'b00) begin
            curBuf  <= pickBuf;
            byteCnt <= '0;
            if (!progOp[pickBuf] && ((pickBuf ? len1 : len0) == '0))
              state <= EngDone;
            else
              state <= EngLoad;
          end
        end
        EngLoad: state <= progOp[curBuf] ? EngMacHi : EngSend;
        EngSend: begin
          if (txReady) begin
            if (isLastByte) state <= EngDone;
            else begin
              byteCnt <= byteCnt + LEN_W'(1);
              if (byteCnt[1:0] == 2'd3) state <= EngLoad;
            end
          end
        end
        EngMacHi: state <= EngMacLo;
        EngMacLo: state <= EngDone;
        EngDone: begin
          busy[curBuf] <= 1'b0;
          irqPulse     <= keepBits[curBuf][IRQ_EN_POS] && gieOn;
          state        <= EngIdle;
        end
        default: state <= EngIdle;
      endcase
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.rdBuf  = curBuf;
    cmd.lane   = byteCnt[1:0];
    cmd.rdIdx  = BUF_IDX_W'(byteCnt >> 2);
    txValid    = 1'b0;
    txLast     = 1'b0;
    unique case (state)
      EngLoad:  cmd.rdReq = 1'b1;
      EngSend: begin
        txValid = 1'b1;
        txLast  = isLastByte;
      end
      EngMacHi: begin
        cmd.macHi = 1'b1;
        cmd.rdReq = 1'b1;
        cmd.rdIdx = BUF_IDX_W'(1);
      end
      EngMacLo: cmd.macLo = 1'b1;
      default: ;
    endcase
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(gieOn)); // R8
  AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txLast))); // R4
  AST_OWNER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state != EngIdle) |-> busy[curBuf]); // R6
  AST_NO_TX_ON_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (state != EngIdle && progOp[curBuf]) |-> !txValid); // R5
endmodule

// File: rtl/dual_buf_tx_mac.sv
module dual_buf_tx_mac
  import txfront_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter logic [47:0] STATION_RESET = 48'h02_00_00_00_00_01,
  localparam int unsigned ADDR_W = BUF_IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady,
  output logic [47:0]       stationAddr,
  output logic              irqPulse
);
  dpCmd_t           cmd;
  logic [LEN_W-1:0] len0, len1;
  logic             gieOn;
  logic [31:0]      ctrlWord0, ctrlWord1;

  tx_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .len0(len0), .len1(len1), .gieOn(gieOn),
    .txReady(txReady), .txValid(txValid), .txLast(txLast),
    .irqPulse(irqPulse), .cmd(cmd), .ctrlWord0(ctrlWord0), .ctrlWord1(ctrlWord1)
  );

  tx_datapath #(.LEN_W(LEN_W), .STATION_RESET(STATION_RESET)) uData (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .ctrlWord0(ctrlWord0), .ctrlWord1(ctrlWord1), .cmd(cmd),
    .len0(len0), .len1(len1), .gieOn(gieOn), .txData(txData),
    .stationAddr(stationAddr)
  );

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> $stable(txData)); // R4
endmodule

// File: tb/dual_buf_tx_mac_test.sv
`timescale 1ns/1ps
module dual_buf_tx_mac_test;
  localparam logic [47:0] DEF_MAC = 48'h02_00_00_00_00_01;

  logic clk = 1'b0, rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0, txReady = 1'b1;
  logic [31:0] busWrData = '0, busRdData;
  logic [7:0] txData;
  logic txValid, txLast, irqPulse;
  logic [47:0] stationAddr;

  int checks = 0, failures = 0;
  int readyMode = 0, cyc = 0;
  logic [7:0] got [0:255];
  int gotN = 0, lastCnt = 0, lastPos = -1, irqCnt = 0, irqWide = 0, stallErr = 0;
  logic prevStall = 1'b0, prevIrq = 1'b0;
  logic [7:0] prevData = '0;

  always #4 clk = ~clk;

  dual_buf_tx_mac uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .txData(txData), .txValid(txValid), .txLast(txLast), .txReady(txReady),
    .stationAddr(stationAddr), .irqPulse(irqPulse)
  );

  // Ready driver: 0 always high, 1 always low, 2 two of three cycles.
  always @(negedge clk) begin
    cyc++;
    txReady <= (readyMode == 0) ? 1'b1 : (readyMode == 1) ? 1'b0 : (cyc % 3 != 1);
  end

  // Stream and interrupt monitor (values before the edge updates).
  always @(posedge clk) begin
    if (prevStall && (!txValid || txData != prevData)) stallErr++;
    prevStall = txValid && !txReady;
    prevData  = txData;
    if (txValid && txReady) begin
      if (gotN < 256) got[gotN] = txData;
      if (txLast) begin lastCnt++; lastPos = gotN; end
      gotN++;
    end
    if (irqPulse) irqCnt++;
    if (irqPulse && prevIrq) irqWide++;
    prevIrq = irqPulse;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  function automatic logic [7:0] patByte(input int seed, input int k);
    return 8'((seed + k * 7) & 8'hFF);
  endfunction

  task automatic loadFrame(input int bufSel, input int len, input int seed);
    for (int w = 0; w < (len + 3) / 4; w++)
      busWrite(12'(bufSel * 12'h800 + w * 4),
               {patByte(seed, 4*w), patByte(seed, 4*w+1), patByte(seed, 4*w+2), patByte(seed, 4*w+3)});
    busWrite(12'(bufSel * 12'h800 + 12'h7F4), 32'(len));
  endtask

  task automatic clearMon();
    gotN = 0; lastCnt = 0; lastPos = -1; irqCnt = 0; irqWide = 0; stallErr = 0;
  endtask

  task automatic waitIdle(input int bufSel);
    logic [31:0] r;
    for (int i = 0; i < 2000; i++) begin
      busRead(12'(bufSel * 12'h800 + 12'h7FC), r);
      if (r[0] == 1'b0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic checkFrame(input string req, input int len, input int seed);
    check({req, " byte count"}, 64'(gotN), 64'(len));
    check({req, " last count"}, 64'(lastCnt), 64'(len > 0 ? 1 : 0));
    if (len > 0) check({req, " last position"}, 64'(lastPos), 64'(len - 1));
    for (int k = 0; k < len && k < 256; k++)
      if (got[k] !== patByte(seed, k)) begin
        check({req, " byte order"}, 64'(got[k]), 64'(patByte(seed, k)));
        break;
      end
  endtask

  task automatic testReset();
    logic [31:0] r;
    check("R1 txValid", 64'(txValid), 64'd0);
    check("R1 irqPulse", 64'(irqPulse), 64'd0);
    check("R1 stationAddr", 64'(stationAddr), 64'(DEF_MAC));
    busRead(12'h7FC, r); check("R1 ctrl0", 64'(r), 64'd0);
    busRead(12'hFFC, r); check("R1 ctrl1", 64'(r), 64'd0);
  endtask

  task automatic testMap();
    logic [31:0] r;
    busWrite(12'h7F4, 32'hFFFF_F123); busRead(12'h7F4, r);
    check("R2 len0 width", 64'(r), 64'h123);
    busWrite(12'hFF4, 32'h0000_0ABC); busRead(12'hFF4, r);
    check("R2 len1 width", 64'(r), 64'h2BC);
    busWrite(12'h7F8, 32'hFFFF_FFFF); busRead(12'h7F8, r);
    check("R2 gie bit", 64'(r), 64'h8000_0000);
    busWrite(12'h804, 32'hDEAD_BEEF); busRead(12'h804, r);
    check("R2 data word", 64'(r), 64'hDEAD_BEEF);
    busWrite(12'hFF8, 32'h1234_5678); busRead(12'hFF8, r);
    check("R2 unused slot", 64'(r), 64'h0);
    busWrite(12'h7F8, 32'h0);
  endtask

  task automatic testSend0();
    clearMon(); readyMode = 0;
    loadFrame(0, 13, 5);
    busWrite(12'h7FC, 32'h1);
    waitIdle(0);
    checkFrame("R3 buf0", 13, 5);
  endtask

  task automatic testSend1Stall();
    clearMon(); readyMode = 2;
    loadFrame(1, 7, 90);
    busWrite(12'hFFC, 32'h1);
    waitIdle(1);
    checkFrame("R3 buf1", 7, 90);
    check("R4 hold under stall", 64'(stallErr), 64'd0);
    readyMode = 0;
  endtask

  task automatic testProgram();
    clearMon();
    busWrite(12'h800, 32'hA1B2_C3D4);
    busWrite(12'h804, 32'hE5F6_7788);
    busWrite(12'hFFC, 32'h3);
    waitIdle(1);
    check("R5 station", 64'(stationAddr), 64'h0000_A1B2_C3D4_E5F6);
    check("R5 no bytes", 64'(gotN), 64'd0);
  endtask

  task automatic testBusyReadback();
    logic [31:0] r;
    clearMon(); readyMode = 1;
    loadFrame(0, 5, 33);
    busWrite(12'h7FC, 32'h0000_00F9);
    repeat (6) @(negedge clk);
    busRead(12'h7FC, r); check("R6 busy readback", 64'(r), 64'hF9);
    busWrite(12'h7FC, 32'h0000_000B);
    busRead(12'h7FC, r); check("R7 S/P ignored while busy", 64'(r), 64'h09);
    readyMode = 0;
    waitIdle(0);
    busRead(12'h7FC, r); check("R6 idle readback", 64'(r), 64'h08);
    checkFrame("R7 single frame", 5, 33);
    check("R7 station kept", 64'(stationAddr), 64'h0000_A1B2_C3D4_E5F6);
  endtask

  task automatic testIrq();
    clearMon();
    busWrite(12'h7F8, 32'h8000_0000);
    loadFrame(0, 3, 1);
    busWrite(12'h7FC, 32'h9);
    waitIdle(0);
    check("R8 irq enabled", 64'(irqCnt), 64'd1);
    check("R8 irq one cycle", 64'(irqWide), 64'd0);
    clearMon();
    busWrite(12'h7FC, 32'h1);
    waitIdle(0);
    check("R8 irq no I bit", 64'(irqCnt), 64'd0);
    clearMon();
    busWrite(12'h7F8, 32'h7FFF_FFFF);
    busWrite(12'h7FC, 32'h9);
    waitIdle(0);
    check("R8 irq global off", 64'(irqCnt), 64'd0);
  endtask

  task automatic testZeroLen();
    logic [31:0] r;
    clearMon();
    busWrite(12'h7F8, 32'h8000_0000);
    busWrite(12'hFF4, 32'h0);
    busWrite(12'hFFC, 32'h9);
    waitIdle(1);
    busRead(12'hFFC, r);
    check("R9 zero length bytes", 64'(gotN), 64'd0);
    check("R9 zero length irq", 64'(irqCnt), 64'd1);
    check("R9 zero length ctrl", 64'(r), 64'h08);
  endtask

  task automatic testNoStart();
    logic [31:0] r;
    clearMon();
    busWrite(12'hFF4, 32'd4);
    busWrite(12'hFFC, 32'h0000_000A);
    repeat (10) @(negedge clk);
    busRead(12'hFFC, r);
    check("R10 ctrl without start", 64'(r), 64'h08);
    check("R10 no bytes", 64'(gotN), 64'd0);
    check("R10 no irq", 64'(irqCnt), 64'd0);
    check("R10 station kept", 64'(stationAddr), 64'h0000_A1B2_C3D4_E5F6);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testSend0();
    testSend1Stall();
    testProgram();
    testBusyReadback();
    testIrq();
    testZeroLen();
    testNoStart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule